// File: doc/BRIEF.md
# Serial Port Tick Generator

This block derives the timing enables of a serial port from the bus clock. The bus clock is the oscillator divided by four. Two stages run in series. The first is a prescaler whose ratio is 1, 3, 4 or 13. The second is a binary chain that divides the prescaler output by a power of two, from 1 to 128. The output of the chain is the 16x oversampling tick used by a receiver. A fixed divide-by-16 after it gives the 1x bit tick used by a transmitter.

The prescaler setting sets the fastest rate available. The rate select can only slow it down. Both outputs are enables that last one bus-clock cycle, so every consumer stays in the bus clock domain.

The rate select is a live input that reset does not change, and it may be changed at any time. A change of either select takes effect cleanly at the next wrap of the stage it controls.

Top module: `baud_tickgen`

## Requirements
- R1: `pre_sel_i` sets the first-stage ratio: 2'b00 is ÷1, 2'b01 is ÷3, 2'b10 is ÷4 and 2'b11 is ÷13.
- R2: `rate_sel_i` = n sets the second-stage ratio to 2^n, from ÷1 (3'b000) to ÷128 (3'b111).
- R3: With both selects steady, `rx16_o` is high once every P·2^n bus cycles, where P is the R1 ratio and n is the R2 value.
- R4: `tx1_o` is high on every 16th `rx16_o` pulse, and only in a cycle where `rx16_o` is also high.
- R5: The ÷3 and ÷13 prescaler ratios give exactly periodic pulses, with the same interval every time.
- R6: Reset does not alter the rate select. The value present at `rate_sel_i` is used from the first cycle after reset.
- R7: While `rst_n` is low, both outputs are low and all counters clear. The first `rx16_o` pulse comes P·2^n cycles after reset is released. The first `tx1_o` pulse comes with the 16th `rx16_o` pulse, 16·P·2^n cycles after release.
- R8: Each pulse lasts one cycle. `tx1_o` is never high in two cycles in a row. `rx16_o` is high in two cycles in a row only when the total ratio is 1.
- R9: A change of `pre_sel_i` or `rate_sel_i` causes no extra or shortened pulse. The new ratio takes effect at the next wrap of the stage the select controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pre_sel_i | input | 2 | Prescaler ratio code |
| rate_sel_i | input | 3 | Power-of-two submultiple code |
| rx16_o | output | 1 | 16x oversampling enable pulse |
| tx1_o | output | 1 | 1x bit enable pulse |

## Verification
The settings with the sharpest edges are the ratio-1 path and the largest ratio. With ÷1/÷1, a design with an off-by-one terminal count would drop pulses. With ÷13/÷128, a truncated counter would wrap early and shorten the period. The non-power-of-two prescaler ratios are measured pulse to pulse. A counter that compares against the wrong terminal count would give ÷4 or ÷12 in place of ÷3 or ÷13.

A reset that clears the rate select, or a first pulse one cycle early or late, shows up in the delay measured from reset release. The selects are also changed in mid-count. A design that applies a new ratio at once would emit a short interval, which the reference model run every cycle catches.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int PSEL_W = 2;
    localparam int RSEL_W = 3;
    localparam int PCNT_W = 4;
    localparam int OVS    = 16;

    // last count value of the prescaler for each select code
    function automatic logic [PCNT_W-1:0] pre_last(input logic [PSEL_W-1:0] sel);
        logic [PCNT_W-1:0] r;
        case (sel)
            2'b00:   r = PCNT_W'(0);
            2'b01:   r = PCNT_W'(2);
            2'b10:   r = PCNT_W'(3);
            default: r = PCNT_W'(12);
        endcase
        return r;
    endfunction

    typedef struct packed {
        logic [PCNT_W-1:0] cnt;
        logic [PCNT_W-1:0] last;
    } pre_st_t;

    typedef struct packed {
        logic rx;
        logic tx;
    } out_st_t;

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PSEL_W-1:0] sel_i,
    output logic              tick_o,
    output logic [PCNT_W-1:0] cnt_o,
    output logic [PCNT_W-1:0] last_o
);
    pre_st_t s_d, s_q;
    logic    wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.cnt >= s_q.last);
        if (wrap) begin
            s_d.cnt  = '0;
            s_d.last = pre_last(sel_i);
        end else begin
            s_d.cnt  = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.last <= pre_last(sel_i);
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o = wrap;
    assign cnt_o  = s_q.cnt;
    assign last_o = s_q.last;
endmodule

// File: rtl/baud_binchain.sv
module baud_binchain #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int CW = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [SEL_W-1:0] sh;
    } chain_st_t;

    chain_st_t     s_d, s_q;
    logic [CW-1:0] lim;
    logic          hit;

    // limit mask: the low sh bits set
    for (genvar i = 0; i < CW; i++) begin : g_mask
        assign lim[i] = (s_q.sh > SEL_W'(i));
    end

    always_comb begin
        s_d = s_q;
        hit = en_i && (s_q.cnt == lim);
        if (en_i) begin
            if (hit) begin
                s_d.cnt = '0;
                s_d.sh  = sel_i;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.sh  <= sel_i;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o = hit;
endmodule

// File: rtl/baud_bitdiv.sv
module baud_bitdiv #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int W = $clog2(DIV);

    logic [W-1:0] cnt_d, cnt_q;
    logic         hit;

    always_comb begin
        cnt_d = cnt_q;
        hit   = en_i && (cnt_q == W'(DIV - 1));
        if (en_i) begin
            cnt_d = hit ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = hit;
endmodule

// File: rtl/baud_tickgen.sv
module baud_tickgen
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PSEL_W-1:0] pre_sel_i,
    input  logic [RSEL_W-1:0] rate_sel_i,
    output logic              rx16_o,
    output logic              tx1_o
);
    logic              pre_tick;
    logic              ovs_tick;
    logic              bit_tick;
    logic [PCNT_W-1:0] pre_cnt;
    logic [PCNT_W-1:0] pre_lst;
    out_st_t           o_d, o_q;

    baud_prescaler u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (pre_sel_i),
        .tick_o (pre_tick),
        .cnt_o  (pre_cnt),
        .last_o (pre_lst)
    );

    baud_binchain #(.SEL_W(RSEL_W)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (pre_tick),
        .sel_i  (rate_sel_i),
        .tick_o (ovs_tick)
    );

    baud_bitdiv #(.DIV(OVS)) u_bit (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ovs_tick),
        .tick_o (bit_tick)
    );

    always_comb begin
        o_d.rx = ovs_tick;
        o_d.tx = bit_tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign rx16_o = o_q.rx;
    assign tx1_o  = o_q.tx;
endmodule

// File: rtl/baud_tickgen_chk.sv
module baud_tickgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx16,
    input logic       tx1,
    input logic       pre_tick,
    input logic [3:0] pre_cnt,
    input logic [3:0] pre_lst
);
    p_tx_on_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx1 |-> rx16);

    p_tx_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx1 |=> !tx1);

    p_rx_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx16 |-> $past(pre_tick));

    p_pre_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cnt <= pre_lst) && (pre_lst <= 4'd12));

    p_reset_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rx16 && !tx1));
endmodule

bind baud_tickgen baud_tickgen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx16     (rx16_o),
    .tx1      (tx1_o),
    .pre_tick (pre_tick),
    .pre_cnt  (pre_cnt),
    .pre_lst  (pre_lst)
);

// File: tb/tb_baud_tickgen.sv
`timescale 1ns/1ps
module tb_baud_tickgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] psel = 2'b00;
    logic [2:0] rsel = 3'b000;
    logic       rx16, tx1;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    bit running = 0;

    // reference model state
    int  m_pre, m_plast, m_chain, m_shift, m_bit;
    bit  e_rx = 0, e_tx = 0;

    always #10 clk = ~clk;

    baud_tickgen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_sel_i  (psel),
        .rate_sel_i (rsel),
        .rx16_o     (rx16),
        .tx1_o      (tx1)
    );

    function automatic int ratio_of(input int code);
        int r[4] = '{1, 3, 4, 13};
        return r[code];
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        bit p, c, b;
        cyc++;
        if (!rst_n) begin
            m_pre = 0; m_plast = ratio_of(psel) - 1;
            m_chain = 0; m_shift = rsel; m_bit = 0;
            e_rx = 0; e_tx = 0;
        end else begin
            p = (m_pre >= m_plast);
            c = p && (m_chain == (1 << m_shift) - 1);
            b = c && (m_bit == 15);
            if (p) begin m_pre = 0; m_plast = ratio_of(psel) - 1; end
            else m_pre++;
            if (p) begin
                if (c) begin m_chain = 0; m_shift = rsel; end
                else m_chain++;
            end
            if (c) m_bit = b ? 0 : m_bit + 1;
            e_rx = c; e_tx = b;
        end
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: actual cycle %0d expected below 190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (running && rst_n) begin
            vectors++;
            if (rx16 !== e_rx) begin
                errors++;
                $display("FAIL R3 rx16 at cycle %0d: actual %b expected %b", cyc, rx16, e_rx);
            end
            vectors++;
            if (tx1 !== e_tx) begin
                errors++;
                $display("FAIL R4 tx1 at cycle %0d: actual %b expected %b", cyc, tx1, e_tx);
            end
        end
    end

    task automatic check(input int act, input int exp, input string req);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rx(output int c);
        do @(negedge clk); while (rx16 !== 1'b1);
        c = cyc;
    endtask

    task automatic wait_tx(output int c);
        do @(negedge clk); while (tx1 !== 1'b1);
        c = cyc;
    endtask

    // reset with a given setting, then check delays and periods
    task automatic run_setting(input int p, input int n, input string req);
        int rel, c0, c1, t0, t1, total;
        total = ratio_of(p) * (1 << n);
        @(negedge clk);
        rst_n = 1'b0; psel = 2'(p); rsel = 3'(n);
        repeat (2) @(negedge clk);
        check(int'(rx16), 0, "R7 rx16 low in reset");
        check(int'(tx1), 0, "R7 tx1 low in reset");
        rst_n = 1'b1; rel = cyc;
        wait_rx(c0);
        check(c0 - rel, total, {"R7 first rx16 delay / R6 ", req});
        wait_rx(c1);
        check(c1 - c0, total, {"R3 rx16 period ", req});
        wait_tx(t0);
        check(t0 - rel, 16 * total, "R7 first tx1 delay");
        wait_tx(t1);
        check(t1 - t0, 16 * total, "R4 tx1 period");
    endtask

    initial begin
        int a, b, c;
        repeat (3) @(negedge clk);
        check(int'(rx16), 0, "R7 rx16 after reset");
        check(int'(tx1), 0, "R7 tx1 after reset");
        running = 1;
        run_setting(0, 0, "R1 R2 ratio 1 R8");
        run_setting(1, 0, "R1 R5 div3");
        run_setting(3, 0, "R1 R5 div13");
        run_setting(2, 2, "R1 R2 div16");
        run_setting(0, 7, "R2 div128");
        run_setting(3, 3, "R1 R2 div104");
        // R5: repeated intervals at div3
        run_setting(1, 1, "R5 div6");
        wait_rx(a); wait_rx(b); wait_rx(c);
        check(c - b, b - a, "R5 steady interval");
        // R9: change selects mid-count, model checks every cycle
        repeat (5) @(negedge clk);
        psel = 2'b11;
        repeat (17) @(negedge clk);
        rsel = 3'b010;
        wait_rx(a); wait_rx(a); wait_rx(b);
        check(b - a, 13 * 4, "R9 new ratio after wrap");
        psel = 2'b00; rsel = 3'b000;
        wait_rx(a); wait_rx(a); wait_rx(a); wait_rx(b);
        check(b - a, 1, "R9 R8 back to ratio 1");
        repeat (40) @(negedge clk);
        running = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule